// File: doc/BRIEF.md
# Switched Output Cyclic Mode Controller

This block drives the enable of a high-side switch that powers external wake-up switches or relays. A host-written 2-bit mode selects among holding the switch open, holding it closed, or one of two cyclic patterns. The cyclic patterns close the switch for a short window at the start of each period. A period is a whole number of timebase ticks, and each tick is a fixed number of clock cycles. Because the switch is powered only for part of each period, an external switch that stays closed draws much less power.

The wake-up input means something only while the switch feeds it. The block therefore emits a sample strobe, and on that strobe it captures the wake input into a held level. If the analog switch reports an overload while the output is driven, the block turns the output off and clears a diagnosis-good flag. It can also raise an interrupt pulse. When the overload happens in sleep, it forces a one-cycle wake-up request and stores the reset-source code 0100 until the host reads it.

Top module: `sw_out_cyc_ctrl`

## Requirements
- R1: After reset, sw_drive, wake_smp, wake_val, irq and wake_req are 0, diag_ok is 1 and rss_code is 0000.
- R2: Mode code 00 (OFF) keeps sw_drive and wake_smp at 0. Mode code 01 (ON) holds sw_drive at 1 and asserts wake_smp in every cycle. A mode write takes effect in the cycle after the write strobe.
- R3: Mode code 10 (cyclic A) restarts its timing on the mode write. Counting clock cycles n from 0 in the first cycle after the write, tick index k = n / TICK_DIV and sw_drive = ((k mod CYC_A) < ON_TICKS).
- R4: Mode code 11 (cyclic B) follows the same rule as R3 but with period CYC_B ticks.
- R5: In a cyclic mode, wake_smp is high for one cycle only, when (n mod TICK_DIV) = TICK_DIV-1 and (k mod period) = ON_TICKS-1. That is the last cycle of each on-window. wake_val takes the value of wake_in from every cycle in which wake_smp is high, and shows it from the next cycle on.
- R6: An overload seen while sw_drive is 1 sets sw_drive and diag_ok to 0 from the next cycle. Both stay 0 in every mode until the next mode write, which restores diag_ok to 1 and applies the written mode.
- R7: An overload seen while sw_drive is 0 has no effect: diag_ok stays 1, and no irq or wake_req follows.
- R8: An accepted overload produces a one-cycle irq pulse in the next cycle when irq_en is 1, and no pulse when irq_en is 0.
- R9: An accepted overload while sleep is 1 produces a one-cycle wake_req pulse in the next cycle and sets rss_code to 0100. With sleep at 0 there is no wake_req and rss_code does not change. A rss_rd strobe clears rss_code to 0000 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 2 | Mode code: 00 off, 01 on, 10 cyclic A, 11 cyclic B |
| irq_en | input | 1 | Supply-fault interrupt enable |
| ovld | input | 1 | Overload flag from the analog switch |
| wake_in | input | 1 | Wake-up input level |
| sleep | input | 1 | System is in sleep mode |
| rss_rd | input | 1 | Host read of the reset-source code (clears it) |
| sw_drive | output | 1 | Switch enable |
| wake_smp | output | 1 | Wake-input sample strobe |
| wake_val | output | 1 | Last sampled wake-input level |
| diag_ok | output | 1 | Output diagnosis status (0 after overload) |
| irq | output | 1 | Supply-fault interrupt pulse |
| wake_req | output | 1 | Forced wake-up request pulse |
| rss_code | output | 4 | Reset-source code |

## Verification
The hardest case to reach is the exact cycle of the sample strobe deep inside a cyclic pattern. Only a fresh mode write fixes the phase, so the bench writes each cyclic mode and then checks every cycle of two full periods against the tick arithmetic. In that sweep it drives a changing wake pattern and checks the held sample. Overloads are injected while the output is on, with sleep and the interrupt enable in each state, and while the output is off, to show that they are then ignored.

// File: rtl/sw_out_cyc_ctrl.sv
module sw_out_cyc_ctrl #(
  parameter int TICK_DIV = 4,
  parameter int CYC_A    = 8,
  parameter int CYC_B    = 16,
  parameter int ON_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [1:0] mode_wdata,
  input  logic       irq_en,
  input  logic       ovld,
  input  logic       wake_in,
  input  logic       sleep,
  input  logic       rss_rd,
  output logic       sw_drive,
  output logic       wake_smp,
  output logic       wake_val,
  output logic       diag_ok,
  output logic       irq,
  output logic       wake_req,
  output logic [3:0] rss_code
);
  localparam int TW   = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam int PMAX = (CYC_A > CYC_B) ? CYC_A : CYC_B;
  localparam int PW   = (PMAX > 2) ? $clog2(PMAX) : 1;
  localparam logic [1:0] M_ON = 2'b01;
  localparam logic [3:0] RSS_OVL = 4'b0100;

  logic [1:0]    mode;
  logic [TW-1:0] tcnt;
  logic [PW-1:0] phase;
  logic          fault;

  wire           tick   = (tcnt == TW'(TICK_DIV - 1));
  wire           cyclic = mode[1];
  wire [PW-1:0]  plast  = mode[0] ? PW'(CYC_B - 1) : PW'(CYC_A - 1);
  wire           in_win = (phase < PW'(ON_TICKS));
  wire           win_end = tick && (phase == PW'(ON_TICKS - 1));

  assign sw_drive = !fault && ((mode == M_ON) || (cyclic && in_win));
  assign wake_smp = !fault && ((mode == M_ON) || (cyclic && win_end));
  assign diag_ok  = !fault;

  wire ovl_evt = ovld && sw_drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= 2'b00;
      tcnt  <= '0;
      phase <= '0;
      fault <= 1'b0;
    end else if (mode_wr) begin
      mode  <= mode_wdata;
      tcnt  <= '0;
      phase <= '0;
      fault <= 1'b0;
    end else begin
      tcnt <= tick ? '0 : tcnt + 1'b1;
      if (tick) phase <= (phase == plast) ? '0 : phase + 1'b1;
      if (ovl_evt) fault <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq      <= 1'b0;
      wake_req <= 1'b0;
      rss_code <= 4'b0000;
      wake_val <= 1'b0;
    end else begin
      irq      <= ovl_evt && irq_en;
      wake_req <= ovl_evt && sleep;
      if (ovl_evt && sleep) rss_code <= RSS_OVL;
      else if (rss_rd)      rss_code <= 4'b0000;
      if (wake_smp) wake_val <= wake_in;
    end
  end

  // R5
  smp_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_smp |-> sw_drive);
  // R6
  ovl_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_drive && ovld && !mode_wr |=> !sw_drive && !diag_ok);
  // R6
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !diag_ok && !mode_wr |=> !diag_ok && !sw_drive);
  // R7
  ovl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_drive && diag_ok && !mode_wr |=> diag_ok && !irq && !wake_req);
  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(irq_en && ovld));
  // R9
  wake_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req);
  // R9
  wake_req_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> rss_code == RSS_OVL);
endmodule

// File: tb/sim_sw_out_cyc_ctrl.sv
module sim_sw_out_cyc_ctrl;
  localparam int D = 4, PA = 8, PB = 16, ONT = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_wr = 0, irq_en = 0, ovld = 0, wake_in = 0, sleep = 0, rss_rd = 0;
  logic [1:0] mode_wdata = 2'b00;
  logic sw_drive, wake_smp, wake_val, diag_ok, irq, wake_req;
  logic [3:0] rss_code;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sw_out_cyc_ctrl #(.TICK_DIV(D), .CYC_A(PA), .CYC_B(PB), .ON_TICKS(ONT)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .irq_en(irq_en), .ovld(ovld), .wake_in(wake_in), .sleep(sleep), .rss_rd(rss_rd),
    .sw_drive(sw_drive), .wake_smp(wake_smp), .wake_val(wake_val), .diag_ok(diag_ok),
    .irq(irq), .wake_req(wake_req), .rss_code(rss_code));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr_mode(input logic [1:0] m);
    @(negedge clk); mode_wr = 1; mode_wdata = m;
    @(negedge clk); mode_wr = 0;
  endtask

  task automatic pulse_ovld(input logic slp, input logic ien);
    sleep = slp; irq_en = ien; ovld = 1;
    @(negedge clk); ovld = 0;
  endtask

  task automatic sweep_cyclic(input logic [1:0] m, input int per, input string req);
    int ev;
    ev = wake_val;
    wr_mode(m);
    for (int n = 0; n < 2 * per * D; n++) begin
      int k, ph;
      bit ed, es;
      if (n > 0) @(negedge clk);
      wake_in = ((n * 7 + 3) % 5) < 2;
      k = n / D; ph = k % per;
      ed = ph < ONT;
      es = ((n % D) == D - 1) && (ph == ONT - 1);
      chk(req, "sw_drive", sw_drive, ed);
      chk("R5", "wake_smp", wake_smp, es);
      chk("R5", "wake_val", wake_val, ev);
      if (es) ev = wake_in;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "sw_drive", sw_drive, 0);
    chk("R1", "wake_smp", wake_smp, 0);
    chk("R1", "irq", irq, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "diag_ok", diag_ok, 1);
    chk("R1", "wake_req", wake_req, 0);
    chk("R1", "rss_code", rss_code, 0);
    chk("R1", "wake_val", wake_val, 0);

    // R2 off then on
    wr_mode(2'b00);
    for (int i = 0; i < 6; i++) begin
      chk("R2", "off sw_drive", sw_drive, 0);
      chk("R2", "off wake_smp", wake_smp, 0);
      @(negedge clk);
    end
    wr_mode(2'b01);
    for (int i = 0; i < 6; i++) begin
      wake_in = i[0];
      chk("R2", "on sw_drive", sw_drive, 1);
      chk("R2", "on wake_smp", wake_smp, 1);
      @(negedge clk);
      chk("R5", "on wake_val", wake_val, i[0]);
    end

    sweep_cyclic(2'b10, PA, "R3");
    sweep_cyclic(2'b11, PB, "R4");
    sweep_cyclic(2'b10, PA, "R3");

    // R6 R8 overload in ON, awake, interrupt enabled
    wr_mode(2'b01);
    pulse_ovld(0, 1);
    chk("R6", "sw_drive after ovl", sw_drive, 0);
    chk("R6", "diag_ok after ovl", diag_ok, 0);
    chk("R8", "irq pulse", irq, 1);
    chk("R9", "no wake_req awake", wake_req, 0);
    chk("R9", "rss unchanged awake", rss_code, 0);
    @(negedge clk);
    chk("R8", "irq one cycle", irq, 0);
    repeat (10) @(negedge clk);
    chk("R6", "still off", sw_drive, 0);
    chk("R6", "still diag low", diag_ok, 0);
    wr_mode(2'b01);
    chk("R6", "rewrite restores drive", sw_drive, 1);
    chk("R6", "rewrite restores diag", diag_ok, 1);

    // R8 disabled, R9 sleep
    pulse_ovld(1, 0);
    chk("R8", "irq masked", irq, 0);
    chk("R9", "wake_req pulse", wake_req, 1);
    chk("R9", "rss code", rss_code, 4);
    @(negedge clk);
    chk("R9", "wake_req one cycle", wake_req, 0);
    chk("R9", "rss held", rss_code, 4);
    rss_rd = 1; @(negedge clk); rss_rd = 0;
    chk("R9", "rss cleared", rss_code, 0);

    // R6 fault holds across cyclic mode, then cleared by write
    wr_mode(2'b10);
    pulse_ovld(0, 1);
    chk("R6", "cyclic ovl diag", diag_ok, 0);
    for (int i = 0; i < PA * D; i++) begin
      chk("R6", "cyclic held off", sw_drive, 0);
      @(negedge clk);
    end

    // R7 overload while output off
    wr_mode(2'b00);
    pulse_ovld(1, 1);
    chk("R7", "diag_ok", diag_ok, 1);
    chk("R7", "irq", irq, 0);
    chk("R7", "wake_req", wake_req, 0);
    chk("R7", "rss", rss_code, 0);
    wr_mode(2'b10);
    repeat (ONT * D) @(negedge clk);
    pulse_ovld(1, 1);
    chk("R7", "off-phase diag", diag_ok, 1);
    chk("R7", "off-phase wake_req", wake_req, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule